// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block decides which of five prioritised localities owns a shared secure device at any time. The locality comes from the access address: a field of address bits sits just above the register offset. Each locality sees its own access register. A write to that register can ask for ownership, give it up, clear a seized flag, or take ownership away from a lower locality.

The arbiter holds the current owner and shows it as a locality number, or as 8'hFF when no locality owns the device. If ownership has to move while the command engine reports a command in flight, the arbiter pulses a cancel request. It then holds the handover until the engine signals completion. Each real change of owner produces a one-cycle locality-changed cause, tagged with the new owner. That cause goes to interrupt logic outside this block.

Access register layout, for writes and reads:

| Bit | Write effect | Read value |
|-----|--------------|------------|
| 0 | request use | request-use flag |
| 1 | give up ownership | active flag |
| 2 | seize | always 0 |
| 3 | write 1 to clear | been-seized flag |
| 4 | none | pending: some other locality has request-use set |
| 7 | none | always 1 |

Top module: `loc_arb`

## Requirements
- R1: The locality is address bits [14:12], and the access register is at offset 0 (address bits [11:0] equal to zero). Writes to any other offset, from locality 4, or from localities 5 to 7 change nothing. Reads for localities 5 to 7, or at a nonzero offset, return 8'h00.
- R2: A write with bit 0 set (request use) depends on ownership. With no owner, the writer becomes owner in that same cycle. If another locality owns the device, the writer's request-use flag is set. If the writer is already the owner, nothing changes.
- R3: When the owner writes bit 1, it gives up ownership. The new owner is the highest-numbered locality whose request-use flag is set. If no flag is set, owner_o becomes 8'hFF.
- R4: When a locality that is not the owner writes bit 1, its own request-use flag is cleared.
- R5: A seize write (bit 2) ignores bits 0 and 1 of the same write. The seize is accepted only when both of these hold:
  - there is no owner, or the writer is numbered higher than the owner;
  - neither the writer nor any higher locality already has a seize pending.
  An accepted seize clears the pending seizes of all lower localities.
- R6: A normal handover clears the old owner's active and request-use flags. A handover caused by a seize clears only the old owner's active flag and sets its been-seized flag.
- R7: The new owner gets its active flag set and its request-use and seize flags cleared. loc_chg_o pulses for one cycle, with loc_chg_id_o equal to the new owner, whenever the owner changes to a valid locality.
- R8: Reads return the access register in the layout given in the table above.
- R9: The handover may wait on a command. If a command is in flight (cmd_busy_i) when a handover is decided, cancel_o pulses and the owner stays the same. The handover happens on cmd_done_i, to the most recently chosen target. Access writes are still processed while a handover waits. Without a command in flight, the handover takes effect in the same cycle.
- R10: After reset there is no owner, all flags are clear, no pulses are active, and every valid locality reads 8'h80.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 15 | Address: locality in [14:12], offset in [11:0] |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| cmd_busy_i | input | 1 | A command is in flight |
| cmd_done_i | input | 1 | The in-flight command finished or was cancelled |
| cancel_o | output | 1 | One-cycle request to cancel the in-flight command |
| owner_o | output | 8 | Owning locality, or 8'hFF for none |
| loc_chg_o | output | 1 | One-cycle locality-changed cause |
| loc_chg_id_o | output | 8 | Locality that the change cause is for |

## Verification
Directed sequences check each kind of access write on its own:
- request with and without an owner;
- give-up by the owner with and without waiting requesters, which separates the priority pick from the release to none;
- give-up by a locality that does not own the device.

A run of competing seizes while a command is held separates the tie-break rules: a lower seize after a higher one, a repeated seize, and a higher seize replacing a lower one. Illegal localities and offsets confirm that those writes are dropped. A long random mix of localities, write values, busy and done timing is then compared every cycle against a behavioural model. This exercises writes that coincide with completion and targets that change while a handover waits.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int LOC_W = 3;
  localparam int N_LOC = 5;
  localparam int OWN_W = 8;
  localparam logic [OWN_W-1:0] OWN_NONE = 8'hFF;

  // write-side bit positions of the access register
  localparam int B_REQ = 0;
  localparam int B_ACT = 1;
  localparam int B_SZ  = 2;
  localparam int B_BS  = 3;

  typedef struct packed {
    logic [N_LOC-1:0] req;
    logic [N_LOC-1:0] act;
    logic [N_LOC-1:0] sz;
    logic [N_LOC-1:0] bs;
    logic [OWN_W-1:0] own;
    logic             chg;
    logic [OWN_W-1:0] chg_loc;
  } arb_st_t;

  // move ownership to n; flag updates on old and new owner
  function automatic arb_st_t hand_over(arb_st_t s, logic [OWN_W-1:0] n);
    arb_st_t r;
    logic moved, taken;
    r = s;
    moved = (s.own != n);
    taken = (n != OWN_NONE) && s.sz[n[LOC_W-1:0]];
    if (moved && s.own != OWN_NONE) begin
      r.act[s.own[LOC_W-1:0]] = 1'b0;
      if (taken) r.bs[s.own[LOC_W-1:0]]  = 1'b1;
      else       r.req[s.own[LOC_W-1:0]] = 1'b0;
    end
    r.own = n;
    if (n != OWN_NONE) begin
      r.act[n[LOC_W-1:0]] = 1'b1;
      r.req[n[LOC_W-1:0]] = 1'b0;
      r.sz[n[LOC_W-1:0]]  = 1'b0;
      if (moved) begin
        r.chg     = 1'b1;
        r.chg_loc = n;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/loc_arb_dec.sv
module loc_arb_dec
  import loc_arb_pkg::*;
#(
  parameter int OFFS_W = 12,
  localparam int ADDR_W = OFFS_W + LOC_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [LOC_W-1:0]  loc_o,
  output logic              acc_hit_o,
  output logic              wr_ok_o,
  output logic              rd_ok_o
);
  assign loc_o     = addr_i[ADDR_W-1:OFFS_W];
  assign acc_hit_o = (addr_i[OFFS_W-1:0] == '0);
  // top locality is read-only
  assign wr_ok_o   = acc_hit_o && (loc_o < LOC_W'(N_LOC - 1));
  assign rd_ok_o   = acc_hit_o && (loc_o < LOC_W'(N_LOC));
endmodule

// File: rtl/loc_arb_pick.sv
module loc_arb_pick #(
  parameter int W  = 5,
  parameter int IW = 3
) (
  input  logic [W-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/loc_arb_rd.sv
module loc_arb_rd
  import loc_arb_pkg::*;
(
  input  logic [LOC_W-1:0] loc_i,
  input  logic             ok_i,
  input  logic [N_LOC-1:0] req_i,
  input  logic [N_LOC-1:0] act_i,
  input  logic [N_LOC-1:0] bs_i,
  output logic [7:0]       rdata_o
);
  logic [7:0] view [N_LOC];

  for (genvar g = 0; g < N_LOC; g++) begin : g_view
    logic pend;
    assign pend    = |(req_i & ~(N_LOC'(1) << g));
    // valid, -, -, pending, been-seized, seize(hidden), active, request
    assign view[g] = {1'b1, 2'b00, pend, bs_i[g], 1'b0, act_i[g], req_i[g]};
  end

  assign rdata_o = ok_i ? view[loc_i] : 8'h00;
endmodule

// File: rtl/loc_arb.sv
module loc_arb
  import loc_arb_pkg::*;
#(
  parameter int OFFS_W = 12,
  localparam int ADDR_W = OFFS_W + LOC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              cmd_busy_i,
  input  logic              cmd_done_i,
  output logic              cancel_o,
  output logic [OWN_W-1:0]  owner_o,
  output logic              loc_chg_o,
  output logic [OWN_W-1:0]  loc_chg_id_o
);
  arb_st_t          cur, nxt;
  logic             hold_q, hold_d;
  logic [OWN_W-1:0] next_q, next_d;
  logic             cancel_q, cancel_d;

  logic [LOC_W-1:0] loc;
  logic             acc_hit, wr_ok, rd_ok;
  logic             pick_found;
  logic [LOC_W-1:0] pick_idx;
  logic [N_LOC-1:0] above, below;
  logic             w_sz, w_act, w_req, w_bs;
  logic [OWN_W-1:0] lo, new_own, ab_to;
  logic             set_new, do_ab;
  logic             wr_unused;

  assign wr_unused = ^wdata_i[7:4];

  loc_arb_dec #(.OFFS_W(OFFS_W)) u_dec (
    .addr_i    (addr_i),
    .loc_o     (loc),
    .acc_hit_o (acc_hit),
    .wr_ok_o   (wr_ok),
    .rd_ok_o   (rd_ok)
  );

  loc_arb_pick #(.W(N_LOC), .IW(LOC_W)) u_pick (
    .vec_i   (cur.req),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  loc_arb_rd u_rd (
    .loc_i   (loc),
    .ok_i    (rd_ok),
    .req_i   (cur.req),
    .act_i   (cur.act),
    .bs_i    (cur.bs),
    .rdata_o (rdata_o)
  );

  always_comb begin
    for (int i = 0; i < N_LOC; i++) begin
      above[i] = (i > int'(loc));
      below[i] = (i < int'(loc));
    end
  end

  // seize overrides request/release bits of the same write
  assign w_sz  = wdata_i[B_SZ];
  assign w_act = wdata_i[B_ACT] & ~w_sz;
  assign w_req = wdata_i[B_REQ] & ~w_sz;
  assign w_bs  = wdata_i[B_BS];
  assign lo    = OWN_W'(loc);

  always_comb begin
    nxt      = cur;
    nxt.chg  = 1'b0;
    hold_d   = hold_q;
    next_d   = next_q;
    cancel_d = 1'b0;
    new_own  = cur.own;
    set_new  = 1'b1;
    do_ab    = 1'b0;
    ab_to    = OWN_NONE;
    if (wr_en_i && wr_ok) begin
      if (w_act) begin
        if (cur.own == lo) begin
          if (pick_found) begin
            set_new = 1'b0;
            do_ab   = 1'b1;
            ab_to   = OWN_W'(pick_idx);
          end else begin
            new_own = OWN_NONE;
          end
        end else begin
          nxt.req[loc] = 1'b0;
        end
      end
      if (w_bs) nxt.bs[loc] = 1'b0;
      if (w_sz && (cur.own == OWN_NONE || lo > cur.own) &&
          !cur.sz[loc] && !(|(cur.sz & above))) begin
        nxt.sz      = nxt.sz & ~below;
        nxt.sz[loc] = 1'b1;
        set_new     = 1'b0;
        do_ab       = 1'b1;
        ab_to       = lo;
      end
      if (w_req && cur.own != lo) begin
        if (cur.own != OWN_NONE) nxt.req[loc] = 1'b1;
        else                     new_own      = lo;
      end
      if (do_ab) begin
        if (cmd_busy_i) begin
          hold_d   = 1'b1;
          next_d   = ab_to;
          cancel_d = 1'b1;
        end else begin
          nxt    = hand_over(nxt, ab_to);
          hold_d = 1'b0;
          next_d = OWN_NONE;
        end
      end else if (set_new) begin
        nxt = hand_over(nxt, new_own);
      end
    end
    // deferred handover completes after any same-cycle write
    if (cmd_done_i && hold_d) begin
      nxt    = hand_over(nxt, next_d);
      hold_d = 1'b0;
      next_d = OWN_NONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur.req     <= '0;
      cur.act     <= '0;
      cur.sz      <= '0;
      cur.bs      <= '0;
      cur.own     <= OWN_NONE;
      cur.chg     <= 1'b0;
      cur.chg_loc <= OWN_NONE;
      hold_q      <= 1'b0;
      next_q      <= OWN_NONE;
      cancel_q    <= 1'b0;
    end else begin
      cur      <= nxt;
      hold_q   <= hold_d;
      next_q   <= next_d;
      cancel_q <= cancel_d;
    end
  end

  assign owner_o      = cur.own;
  assign loc_chg_o    = cur.chg;
  assign loc_chg_id_o = cur.chg_loc;
  assign cancel_o     = cancel_q;

  AST_OWNER_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owner_o == OWN_NONE || owner_o < OWN_W'(N_LOC - 1)); // R1
  AST_TOP_LOC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cur.req[N_LOC-1] && !cur.sz[N_LOC-1] && !cur.act[N_LOC-1]); // R1
  AST_ONE_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cur.act)); // R7
  AST_OWNER_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owner_o != OWN_NONE |-> cur.act[owner_o[LOC_W-1:0]]); // R7
  AST_CHG_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_chg_o |-> loc_chg_id_o == owner_o); // R7
  AST_SEIZE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cur.sz)); // R5
  AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q && !wr_en_i && !cmd_done_i |=> owner_o == $past(owner_o)); // R9
  AST_CANCEL_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_o |-> $past(cmd_busy_i)); // R9
endmodule

// File: tb/loc_arb_tb.sv
`timescale 1ns/1ps
module loc_arb_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [14:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        cmd_busy_i = 1'b0;
  logic        cmd_done_i = 1'b0;
  logic [7:0]  rdata_o, owner_o, loc_chg_id_o;
  logic        cancel_o, loc_chg_o;

  int checks = 0, fails = 0;
  bit run = 0;

  // reference model state
  int m_req[5], m_act[5], m_sz[5], m_bs[5];
  int m_own, m_hold, m_next, m_chg, m_chgl, m_cancel;

  always #2.5 clk_i = ~clk_i;

  loc_arb u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .cmd_busy_i(cmd_busy_i),
    .cmd_done_i(cmd_done_i), .cancel_o(cancel_o), .owner_o(owner_o),
    .loc_chg_o(loc_chg_o), .loc_chg_id_o(loc_chg_id_o)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic void m_reset();
    for (int k = 0; k < 5; k++) begin
      m_req[k] = 0; m_act[k] = 0; m_sz[k] = 0; m_bs[k] = 0;
    end
    m_own = -1; m_hold = 0; m_next = -1; m_chg = 0; m_chgl = 255; m_cancel = 0;
  endfunction

  function automatic void m_move(int n);
    bit moved, taken;
    moved = (m_own != n);
    taken = (n >= 0) && (m_sz[n] != 0);
    if (moved && m_own >= 0) begin
      m_act[m_own] = 0;
      if (taken) m_bs[m_own] = 1; else m_req[m_own] = 0;
    end
    m_own = n;
    if (n >= 0) begin
      m_act[n] = 1; m_req[n] = 0; m_sz[n] = 0;
      if (moved) begin m_chg = 1; m_chgl = n; end
    end
  endfunction

  function automatic int m_read(int a);
    int l, off, pend;
    l = (a >> 12) & 7;
    off = a & 12'hFFF;
    if (off != 0 || l > 4) return 0;
    pend = 0;
    for (int k = 0; k < 5; k++) if (k != l && m_req[k] != 0) pend = 1;
    return 8'h80 | (pend << 4) | (m_bs[l] << 3) | (m_act[l] << 1) | m_req[l];
  endfunction

  function automatic void m_step();
    int l, off, nown, abto, c;
    bit sz, a, rq, b, setn, doab, hi;
    m_chg = 0; m_cancel = 0;
    l = (int'(addr_i) >> 12) & 7;
    off = int'(addr_i) & 12'hFFF;
    if (wr_en_i && off == 0 && l < 4) begin
      sz = wdata_i[2]; a = wdata_i[1] && !sz; rq = wdata_i[0] && !sz; b = wdata_i[3];
      nown = m_own; setn = 1; doab = 0; abto = -1;
      if (a) begin
        if (m_own == l) begin
          c = -1;
          for (int k = 4; k >= 0; k--) if (m_req[k] != 0 && c < 0) c = k;
          if (c >= 0) begin setn = 0; doab = 1; abto = c; end
          else nown = -1;
        end else m_req[l] = 0;
      end
      if (b) m_bs[l] = 0;
      if (sz && (m_own < 0 || l > m_own)) begin
        hi = 0;
        for (int k = l + 1; k < 5; k++) if (m_sz[k] != 0) hi = 1;
        if (m_sz[l] == 0 && !hi) begin
          for (int k = 0; k < l; k++) m_sz[k] = 0;
          m_sz[l] = 1; setn = 0; doab = 1; abto = l;
        end
      end
      if (rq && m_own != l) begin
        if (m_own >= 0) m_req[l] = 1; else nown = l;
      end
      if (doab) begin
        if (cmd_busy_i) begin m_hold = 1; m_next = abto; m_cancel = 1; end
        else begin m_move(abto); m_hold = 0; m_next = -1; end
      end else if (setn) m_move(nown);
    end
    if (cmd_done_i && m_hold != 0) begin m_move(m_next); m_hold = 0; m_next = -1; end
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) m_reset();
    else m_step();
    if (run) begin
      #1;
      chk("R3 owner vs model", owner_o, (m_own < 0) ? 255 : m_own);
      chk("R7 change pulse vs model", loc_chg_o, m_chg);
      if (m_chg != 0) chk("R7 change id vs model", loc_chg_id_o, m_chgl);
      chk("R9 cancel vs model", cancel_o, m_cancel);
      chk("R8 read vs model", rdata_o, m_read(int'(addr_i)));
    end
  end

  task automatic wr(int l, int v, int off = 0);
    @(negedge clk_i);
    addr_i = 15'((l << 12) | off); wdata_i = 8'(v); wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk_i); cmd_done_i = 1'b1;
    @(negedge clk_i); cmd_done_i = 1'b0;
  endtask

  task automatic rd(int l, output int v);
    addr_i = 15'(l << 12);
    #0.5 v = rdata_o;
  endtask

  initial begin
    int v;
    #2 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    run = 1;
    rd(0, v); chk("R10 reset read", v, 8'h80);
    chk("R10 reset owner", owner_o, 8'hFF);
    chk("R10 reset pulses", {loc_chg_o, cancel_o}, 0);

    wr(2, 1);
    chk("R2 request with no owner", owner_o, 2);
    chk("R7 change id", {loc_chg_o, loc_chg_id_o}, 9'h102);
    rd(2, v); chk("R7 new owner flags", v, 8'h82);
    wr(0, 1);
    rd(0, v); chk("R2 request queued", v, 8'h81);
    rd(2, v); chk("R8 pending seen by owner", v, 8'h92);
    wr(1, 1);
    rd(1, v); chk("R2 second request", v, 8'h91);
    wr(1, 2);
    rd(1, v); chk("R4 non-owner release clears request", v, 8'h90);
    wr(2, 1);
    chk("R2 owner request no effect", {loc_chg_o, owner_o}, 9'h002);

    wr(2, 2);
    chk("R3 release to highest requester", owner_o, 0);
    rd(2, v); chk("R6 normal handover flags", v, 8'h80);
    wr(0, 2);
    chk("R3 release to none", owner_o, 8'hFF);
    chk("R7 no pulse for none", loc_chg_o, 0);

    wr(4, 1);
    chk("R1 locality 4 write ignored", owner_o, 8'hFF);
    wr(5, 1);
    chk("R1 locality 5 write ignored", owner_o, 8'hFF);
    wr(1, 1, 4);
    chk("R1 other offset ignored", owner_o, 8'hFF);
    rd(5, v); chk("R1 locality 5 reads zero", v, 0);
    rd(4, v); chk("R8 locality 4 readable", v, 8'h80);

    wr(1, 1); wr(0, 1);
    wr(3, 4);
    chk("R5 seize accepted", {loc_chg_o, owner_o}, 9'h103);
    rd(1, v); chk("R6 seized victim", v, 8'h98);
    rd(3, v); chk("R8 seize hidden on owner", v, 8'h92);
    wr(1, 8);
    rd(1, v); chk("R8 been-seized cleared", v, 8'h90);
    wr(2, 4);
    chk("R5 lower seize ignored", {cancel_o, owner_o}, 9'h003);

    cmd_busy_i = 1'b1;
    wr(3, 2);
    chk("R9 cancel on busy release", {cancel_o, owner_o}, 9'h103);
    done_pulse();
    chk("R9 deferred handover", {loc_chg_o, owner_o}, 9'h100);
    rd(3, v); chk("R6 deferred normal handover", v, 8'h80);

    wr(2, 4);
    chk("R9 seize while busy", {cancel_o, owner_o}, 9'h100);
    rd(2, v); chk("R8 pending seize hidden", v, 8'h80);
    wr(1, 4);
    chk("R5 seize below pending one ignored", cancel_o, 0);
    wr(2, 4);
    chk("R5 repeated seize ignored", cancel_o, 0);
    wr(3, 4);
    chk("R5 higher seize replaces", {cancel_o, owner_o}, 9'h100);
    done_pulse();
    chk("R5 highest seizer wins", {loc_chg_o, loc_chg_id_o}, 9'h103);
    rd(0, v); chk("R6 victim after deferred seize", v, 8'h88);
    cmd_busy_i = 1'b0;
    wr(2, 1);
    rd(3, v); chk("R8 pending on owner", v, 8'h92);

    for (int i = 0; i < 4000; i++) begin
      int sel;
      @(negedge clk_i);
      sel = $urandom_range(0, 4);
      wr_en_i = ($urandom_range(0, 2) != 0);
      addr_i = 15'(($urandom_range(0, 7) << 12) | (($urandom_range(0, 9) == 0) ? 4 : 0));
      wdata_i = (sel == 4) ? 8'($urandom_range(0, 255)) : 8'(1 << sel);
      if ($urandom_range(0, 9) == 0) cmd_busy_i = ~cmd_busy_i;
      cmd_done_i = ($urandom_range(0, 6) == 0);
    end
    @(negedge clk_i);
    wr_en_i = 1'b0; cmd_done_i = 1'b0;
    repeat (3) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule